// File: doc/BRIEF.md
# Audio Bit and Frame Clock Generator

This block sits at the clocking edge of an audio serial port running as clock master. From one system master clock it derives the serial bit clock, the frame (left/right) clock and two single-cycle strobes that the data path can use as enables: one marks the start of every bit period, the other the start of every frame. Everything runs in the master clock domain. The only output that is not a register is the bit clock when the bit period is a single master cycle. In that case the inverted master clock is passed through a glitch-free gate.

Software sets an oversampling ratio, which is master clock cycles per frame (for example 256 for 12.288 MHz at 48 kHz), and a bit-clock selector. A mode flag decides what the selector means. In divide mode the bit period is 1, 2, 4, 8 or 16 master cycles. In multiply mode the frame holds 32 or 64 bit clocks. The block checks each configuration before using it and refuses any setting that cannot place a whole, even number of bit periods in a frame. It also refuses a setting that leaves too few bits for two samples of the configured width. A refused setting raises an error flag and keeps all clock outputs low.

A new configuration is taken only when the generator is idle or at the last master cycle of a frame, so a reprogram never cuts a clock pulse short.

Top module: `aclk_gen`

## Requirements
- R1: While `rst_n` is low, `bclk_o`, `lrclk_o`, `bit_stb_o`, `frame_stb_o`, `locked_o` and `cfg_err_o` are all 0. The first rising master clock edge after release loads the configuration.
- R2: Divide mode (`cfg_mul_mode`=0) with `cfg_sel`=s, where 1≤s≤4, gives a bit period of 2^s master cycles. `bclk_o` is low for the first half of each period and high for the second half.
- R3: Divide mode with `cfg_sel`=0 gives a bit period of one master cycle. `bclk_o` is then the inverted master clock, gated by the running state: low while the master clock is high, high while it is low.
- R4: Multiply mode (`cfg_mul_mode`=1) with `cfg_sel`=0 or 1 puts 32 or 64 bit periods in a frame. Each bit period is ratio/32 or ratio/64 master cycles.
- R5: For a frame of N bit periods, `lrclk_o` is low for bit periods 0..N/2-1 and high for the rest. It changes only at the start of a bit period, which is where `bclk_o` falls.
- R6: `bit_stb_o` is high during the first master cycle of every bit period. `frame_stb_o` is high during the first master cycle of every frame.
- R7: A configuration is refused in any of these cases: the ratio is 0; the selector is out of range (above 4 in divide mode, above 1 in multiply mode); the ratio does not split exactly; the number of bit periods per frame is odd; or the bit period is odd and greater than 1. A refused configuration sets `cfg_err_o`=1 and `locked_o`=0 and holds `bclk_o`, `lrclk_o` and both strobes at 0.
- R8: A configuration whose bit periods per frame number fewer than twice `cfg_width` is refused in the same way as R7.
- R9: A change of configuration inputs during a running frame has no effect on the outputs until the master cycle after that frame's last cycle.
- R10: Ratios that are not powers of two, such as 192, 272 and 1536, are accepted whenever they split exactly under R2 to R8.
- R11: While idle, the configuration is re-evaluated every cycle. The first legal one clears `cfg_err_o`, sets `locked_o` and starts a frame in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ratio | input | OSR_W | Master clock cycles per frame |
| cfg_mul_mode | input | 1 | 0: selector is a master clock divisor exponent; 1: selector picks 32 or 64 bits per frame |
| cfg_sel | input | SEL_W | Bit clock selector |
| cfg_width | input | WID_W | Sample width in bits |
| bclk_o | output | 1 | Bit clock |
| lrclk_o | output | 1 | Frame (left/right) clock |
| bit_stb_o | output | 1 | First master cycle of each bit period |
| frame_stb_o | output | 1 | First master cycle of each frame |
| locked_o | output | 1 | Generator running with a legal configuration |
| cfg_err_o | output | 1 | Last evaluated configuration was refused |

## Verification
The assertions take for granted that the configuration inputs are synchronous to the master clock and free of unknown values at every rising edge where they may be loaded. The alignment and hold properties also assume reset is applied before the first edge. The bench changes the configuration only at the falling master clock edge. It mixes directed settings with random ones drawn from ranges that include out-of-range selectors, ratios that do not split, and widths too large for the frame. Some of these changes land in the middle of a running frame to exercise the frame-boundary hand-over.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

    typedef enum logic {
        BCLK_DIVIDE   = 1'b0,
        BCLK_MULTIPLY = 1'b1
    } bclk_mode_e;

endpackage

// File: rtl/aclk_cfg_check.sv
module aclk_cfg_check
    import aclk_pkg::*;
#(
    parameter int OSR_W         = 12,
    parameter int SEL_W         = 3,
    parameter int WID_W         = 6,
    parameter int MAX_DIV_LOG2  = 4,
    parameter int MUL_BASE_LOG2 = 5,
    parameter int MUL_STEPS     = 2
) (
    input  logic [OSR_W-1:0] ratio_i,
    input  bclk_mode_e       mode_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [WID_W-1:0] width_i,
    output logic             ok_o,
    output logic [OSR_W-1:0] period_o,
    output logic [OSR_W-1:0] bits_o
);

    localparam logic [OSR_W-1:0] ONE = OSR_W'(1);

    logic [7:0]       mul_sh;
    logic [OSR_W-1:0] mask;
    logic             sel_ok;
    logic [OSR_W:0]   need;

    always_comb begin
        mul_sh = 8'(MUL_BASE_LOG2) + 8'(sel_i);
        if (mode_i == BCLK_DIVIDE) begin
            sel_ok   = (int'(sel_i) <= MAX_DIV_LOG2);
            period_o = ONE << sel_i;
            bits_o   = ratio_i >> sel_i;
            mask     = period_o - ONE;
        end else begin
            sel_ok   = (int'(sel_i) < MUL_STEPS);
            bits_o   = ONE << mul_sh;
            period_o = ratio_i >> mul_sh;
            mask     = bits_o - ONE;
        end
        need = {1'b0, OSR_W'(width_i)} << 1;
        ok_o = (ratio_i != '0) && sel_ok && ((ratio_i & mask) == '0)
            && (bits_o != '0) && (period_o != '0) && !bits_o[0]
            && ((period_o == ONE) || !period_o[0])
            && ({1'b0, bits_o} >= need);
    end

    // R10: an accepted split always multiplies back to the ratio
    logic [2*OSR_W-1:0] prod;
    assign prod = period_o * bits_o;

    always_comb begin
        if (ok_o) begin
            assert_exact_split_R10: assert (prod == {{OSR_W{1'b0}}, ratio_i});
        end
    end

endmodule

// File: rtl/aclk_timebase.sv
module aclk_timebase #(
    parameter int OSR_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_ok_i,
    input  logic [OSR_W-1:0] cfg_period_i,
    input  logic [OSR_W-1:0] cfg_bits_i,
    output logic             run_o,
    output logic             err_o,
    output logic             div1_o,
    output logic             bclk_o,
    output logic             lr_o,
    output logic             bit_stb_o,
    output logic             frm_stb_o
);

    localparam logic [OSR_W-1:0] ONE = OSR_W'(1);

    typedef struct packed {
        logic             run;
        logic             err;
        logic             div1;
        logic [OSR_W-1:0] per;
        logic [OSR_W-1:0] bits;
        logic [OSR_W-1:0] ph;
        logic [OSR_W-1:0] bc;
        logic             bclk;
        logic             lr;
        logic             bit_stb;
        logic             frm_stb;
    } tb_state_t;

    tb_state_t st_d, st_q;
    logic      frame_end;
    logic      load;

    always_comb begin
        st_d      = st_q;
        frame_end = st_q.run && (st_q.ph == st_q.per - ONE)
                    && (st_q.bc == st_q.bits - ONE);
        load      = !st_q.run || frame_end;

        if (load) begin
            st_d.ph = '0;
            st_d.bc = '0;
            if (cfg_ok_i) begin
                st_d.run  = 1'b1;
                st_d.err  = 1'b0;
                st_d.per  = cfg_period_i;
                st_d.bits = cfg_bits_i;
                st_d.div1 = (cfg_period_i == ONE);
            end else begin
                st_d.run  = 1'b0;
                st_d.err  = 1'b1;
                st_d.div1 = 1'b0;
            end
        end else if (st_q.ph == st_q.per - ONE) begin
            st_d.ph = '0;
            st_d.bc = st_q.bc + ONE;
        end else begin
            st_d.ph = st_q.ph + ONE;
        end

        st_d.bclk    = st_d.run && !st_d.div1 && (st_d.ph >= (st_d.per >> 1));
        st_d.lr      = st_d.run && (st_d.bc >= (st_d.bits >> 1));
        st_d.bit_stb = st_d.run && (st_d.ph == '0);
        st_d.frm_stb = st_d.run && (st_d.ph == '0) && (st_d.bc == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_o     = st_q.run;
    assign err_o     = st_q.err;
    assign div1_o    = st_q.div1;
    assign bclk_o    = st_q.bclk;
    assign lr_o      = st_q.lr;
    assign bit_stb_o = st_q.bit_stb;
    assign frm_stb_o = st_q.frm_stb;

    assert_err_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |-> !st_q.run);

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.run |-> (!st_q.bclk && !st_q.lr && !st_q.bit_stb && !st_q.frm_stb));

    assert_phase_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run |-> (st_q.ph < st_q.per) && (st_q.bc < st_q.bits));

    assert_duty_edges_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && $past(st_q.run) && !st_q.div1 && !$stable(st_q.bclk))
        |-> ((st_q.ph == '0) || (st_q.ph == (st_q.per >> 1))));

    assert_lr_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && $past(st_q.run) && !$stable(st_q.lr)) |-> st_q.bit_stb);

    assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && $past(st_q.run) && (!$stable(st_q.per) || !$stable(st_q.bits)))
        |-> st_q.frm_stb);

endmodule

// File: rtl/aclk_pin_mux.sv
module aclk_pin_mux (
    input  logic clk,
    input  logic gate_i,
    input  logic bclk_reg_i,
    output logic bclk_o
);

    // The gate is updated at the rising edge, while the inverted clock is
    // low, so the pass-through path cannot produce a shortened pulse.
    always_comb begin
        if (gate_i) begin
            bclk_o = ~clk;
        end else begin
            bclk_o = bclk_reg_i;
        end
    end

endmodule

// File: rtl/aclk_gen.sv
module aclk_gen
    import aclk_pkg::*;
#(
    parameter int OSR_W         = 12,
    parameter int SEL_W         = 3,
    parameter int WID_W         = 6,
    parameter int MAX_DIV_LOG2  = 4,
    parameter int MUL_BASE_LOG2 = 5,
    parameter int MUL_STEPS     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OSR_W-1:0] cfg_ratio,
    input  logic             cfg_mul_mode,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [WID_W-1:0] cfg_width,
    output logic             bclk_o,
    output logic             lrclk_o,
    output logic             bit_stb_o,
    output logic             frame_stb_o,
    output logic             locked_o,
    output logic             cfg_err_o
);

    logic             chk_ok;
    logic [OSR_W-1:0] chk_period;
    logic [OSR_W-1:0] chk_bits;
    logic             tb_run;
    logic             tb_div1;
    logic             tb_bclk;
    bclk_mode_e       mode;

    assign mode = bclk_mode_e'(cfg_mul_mode);

    aclk_cfg_check #(
        .OSR_W         (OSR_W),
        .SEL_W         (SEL_W),
        .WID_W         (WID_W),
        .MAX_DIV_LOG2  (MAX_DIV_LOG2),
        .MUL_BASE_LOG2 (MUL_BASE_LOG2),
        .MUL_STEPS     (MUL_STEPS)
    ) u_check (
        .ratio_i  (cfg_ratio),
        .mode_i   (mode),
        .sel_i    (cfg_sel),
        .width_i  (cfg_width),
        .ok_o     (chk_ok),
        .period_o (chk_period),
        .bits_o   (chk_bits)
    );

    aclk_timebase #(
        .OSR_W (OSR_W)
    ) u_timebase (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_ok_i     (chk_ok),
        .cfg_period_i (chk_period),
        .cfg_bits_i   (chk_bits),
        .run_o        (tb_run),
        .err_o        (cfg_err_o),
        .div1_o       (tb_div1),
        .bclk_o       (tb_bclk),
        .lr_o         (lrclk_o),
        .bit_stb_o    (bit_stb_o),
        .frm_stb_o    (frame_stb_o)
    );

    aclk_pin_mux u_pin (
        .clk        (clk),
        .gate_i     (tb_run & tb_div1),
        .bclk_reg_i (tb_bclk),
        .bclk_o     (bclk_o)
    );

    assign locked_o = tb_run;

    assert_lock_err_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(locked_o && cfg_err_o));

endmodule

// File: tb/aclk_gen_tb.sv
module aclk_gen_tb;

    localparam int CLK_PERIOD = 10;
    localparam int OSR_W = 12;
    localparam int SEL_W = 3;
    localparam int WID_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [OSR_W-1:0] cfg_ratio = '0;
    logic             cfg_mul_mode = 1'b0;
    logic [SEL_W-1:0] cfg_sel = '0;
    logic [WID_W-1:0] cfg_width = '0;
    logic bclk_o, lrclk_o, bit_stb_o, frame_stb_o, locked_o, cfg_err_o;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string cur_tag = "R1";

    // bench reference state
    bit m_run = 0, m_err = 0;
    int m_per = 1, m_nb = 2, m_ph = 0, m_bc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    aclk_gen u_dut (
        .clk (clk), .rst_n (rst_n), .cfg_ratio (cfg_ratio),
        .cfg_mul_mode (cfg_mul_mode), .cfg_sel (cfg_sel), .cfg_width (cfg_width),
        .bclk_o (bclk_o), .lrclk_o (lrclk_o), .bit_stb_o (bit_stb_o),
        .frame_stb_o (frame_stb_o), .locked_o (locked_o), .cfg_err_o (cfg_err_o)
    );

    function automatic bit b_legal(int osr, bit mul, int sel, int wid,
                                   output int per, output int nb);
        per = 1; nb = 2;
        if (osr == 0) return 0;
        if (!mul) begin
            if (sel > 4) return 0;
            per = 1 << sel;
            if (osr % per != 0) return 0;
            nb = osr / per;
        end else begin
            if (sel > 1) return 0;
            nb = 32 << sel;
            if (osr % nb != 0) return 0;
            per = osr / nb;
        end
        if (nb % 2 != 0) return 0;
        if (per > 1 && per % 2 != 0) return 0;
        if (nb < 2 * wid) return 0;
        return 1;
    endfunction

    task automatic chk(string req, string sig, logic got, logic exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s [%s] %s got %b expected %b at %0t",
                     req, cur_tag, sig, got, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        int p, n;
        bit ok;
        if (!rst_n) begin
            m_run = 0; m_err = 0; m_ph = 0; m_bc = 0;
        end else if (!m_run || (m_ph == m_per - 1 && m_bc == m_nb - 1)) begin
            ok = b_legal(int'(cfg_ratio), cfg_mul_mode, int'(cfg_sel),
                         int'(cfg_width), p, n);
            m_ph = 0; m_bc = 0;
            if (ok) begin
                m_run = 1; m_err = 0; m_per = p; m_nb = n;
            end else begin
                m_run = 0; m_err = 1;
            end
        end else if (m_ph == m_per - 1) begin
            m_ph = 0; m_bc++;
        end else begin
            m_ph++;
        end
        // high phase of the master clock
        #2;
        chk(m_per == 1 ? "R3" : "R2", "bclk_hi", bclk_o,
            m_run && m_per != 1 && m_ph >= m_per / 2);
        // low phase of the master clock
        #4;
        chk(m_per == 1 ? "R3" : "R2", "bclk_lo", bclk_o,
            m_run && (m_per == 1 || m_ph >= m_per / 2));
        chk("R5", "lrclk", lrclk_o, m_run && m_bc >= m_nb / 2);
        chk("R6", "bit_stb", bit_stb_o, m_run && m_ph == 0);
        chk("R6", "frame_stb", frame_stb_o, m_run && m_ph == 0 && m_bc == 0);
        chk(cur_tag, "locked", locked_o, m_run);
        chk(cur_tag, "cfg_err", cfg_err_o, m_err);
    end

    task automatic set_cfg(int osr, bit mul, int sel, int wid);
        @(negedge clk);
        cfg_ratio    = OSR_W'(osr);
        cfg_mul_mode = mul;
        cfg_sel      = SEL_W'(sel);
        cfg_width    = WID_W'(wid);
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    // let the current frame finish, then run the pending one for frames
    task automatic run_cfg(string tag, int osr, bit mul, int sel, int wid, int frames);
        int p, n;
        set_cfg(osr, mul, sel, wid);
        cur_tag = tag;
        wait_cyc(m_run ? (m_nb - m_bc) * m_per + 2 : 2);
        if (b_legal(osr, mul, sel, wid, p, n)) wait_cyc(frames * osr);
        else wait_cyc(4);
    endtask

    initial begin
        void'($urandom(32'h5EED_A11C));
        cur_tag = "R1";
        wait_cyc(3);
        // R1: outputs during reset
        chk("R1", "reset locked", locked_o, 1'b0);
        chk("R1", "reset err", cfg_err_o, 1'b0);
        chk("R1", "reset lrclk", lrclk_o, 1'b0);
        set_cfg(256, 0, 2, 16);
        rst_n = 1'b1;
        cur_tag = "R2";
        wait_cyc(2 * 256);
        run_cfg("R2", 128, 0, 1, 16, 2);
        run_cfg("R3", 128, 0, 0, 24, 2);
        run_cfg("R4", 256, 1, 1, 24, 2);
        run_cfg("R4", 192, 1, 0, 16, 2);
        run_cfg("R10", 272, 0, 3, 16, 2);
        run_cfg("R10", 1536, 0, 4, 32, 1);
        run_cfg("R10", 1536, 1, 1, 32, 1);
        run_cfg("R7", 272, 0, 4, 8, 1);
        run_cfg("R7", 192, 1, 1, 16, 1);
        run_cfg("R7", 256, 0, 5, 16, 1);
        run_cfg("R7", 0, 0, 1, 16, 1);
        run_cfg("R7", 256, 1, 2, 16, 1);
        run_cfg("R8", 64, 0, 1, 17, 1);
        chk("R8", "width reject", cfg_err_o, 1'b1);
        run_cfg("R11", 64, 0, 1, 16, 2);
        chk("R11", "recovered lock", locked_o, 1'b1);
        // R9: mid-frame reprogram is held until the frame ends
        run_cfg("R9", 128, 0, 1, 16, 1);
        cur_tag = "R9";
        wait_cyc(10);
        set_cfg(128, 0, 2, 16);
        wait_cyc(300);
        set_cfg(64, 0, 0, 8);
        wait_cyc(40);
        set_cfg(0, 0, 0, 8);
        wait_cyc(200);
        // random mix
        for (int i = 0; i < 14; i++) begin
            int osr, sel, wid;
            bit mul;
            osr = ($urandom % 2 == 0) ? (($urandom % 24) + 1) * 64 : $urandom % 1600;
            mul = 1'($urandom % 2);
            sel = $urandom % 6;
            wid = 8 + $urandom % 25;
            run_cfg("R10", osr, mul, sel, wid, 2);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired at %0t", $time);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule